// File: doc/BRIEF.md
# Alias-Aware Fabric Window Guard

This block sits on a 16-bit system fabric in front of a peripheral with a small register space. Each request that falls in the low 16 KiB of the fabric map (0x0000 to 0x3FFF) is decoded here. A request that is allowed goes to the peripheral with an offset that has been folded to the mapped size. A request that is refused gets a one-cycle error response. A request outside the window is left to other targets: the block neither selects the peripheral nor raises an error for it.

Privilege checks run on the folded offset, not on the raw address. Every mirror copy of a register is therefore covered by the same protected range. Aliasing itself is a mode. With it off, only the primary copy, below the mapped size, is reachable, and the mirror copies fail for every requester. A separate configuration port holds the alias enable, the mapped size and the protected range. Only privileged writers can change it, and a sticky lock freezes it until reset.

Top module: `fab_alias_guard`

## Requirements
- R1: Only requests with address bits [15:14] equal to zero (0x0000 to 0x3FFF) may assert `periph_sel` or `resp_err`. Requests at 0x4000 to 0xFFFF produce neither.
- R2: The peripheral offset is the address masked to the mapped size. `size_sel` 0 keeps the low 12 bits (4 KiB), 1 keeps 13 bits (8 KiB), and 2 or 3 keeps 14 bits (16 KiB).
- R3: With aliasing disabled, a window address that has any bit set above the mapped size is refused with `resp_err` for privileged and unprivileged requests alike.
- R4: With aliasing enabled, such an address reaches the peripheral at its folded offset. For example, with 4 KiB mapped, 0x0010, 0x1010, 0x2010 and 0x3010 all give offset 0x010.
- R5: An unprivileged request whose folded offset lies in the inclusive range [base, limit] is refused at every mirror. Privileged requests are not refused by this range check.
- R6: A refused request raises `resp_err` for exactly one cycle and keeps `periph_sel` and `periph_we` low. `resp_rdata` is zero whenever `periph_sel` is low.
- R7: Responses appear in the cycle after the request edge. In a cycle with no request, `periph_sel` and `resp_err` are low.
- R8: The configuration port decodes these fields. Address 0 is control: bit 0 alias enable, bits 2:1 `size_sel`, bit 3 lock. Address 1 is the protected base, in bits 13:0. Address 2 is the protected limit, in bits 13:0. An unprivileged configuration write is rejected: `cfg_err` is raised one cycle later and the configuration is unchanged. A write to address 3 is also rejected.
- R9: After a control write with bit 3 set, all later configuration writes are rejected with `cfg_err` and change nothing until reset.
- R10: After reset, aliasing is off, 4 KiB is mapped, the protected range is 0x0000 to 0x3FFF, and the lock is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Fabric request present |
| req_addr | input | 16 | Fabric address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | Requester is privileged |
| periph_rdata | input | 16 | Read data from the peripheral |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_priv | input | 1 | Configuration writer is privileged |
| cfg_addr | input | 2 | Configuration field select |
| cfg_wdata | input | 16 | Configuration write data |
| periph_sel | output | 1 | Peripheral access granted |
| periph_off | output | 14 | Folded peripheral offset |
| periph_we | output | 1 | Granted access is a write |
| resp_err | output | 1 | Request refused |
| resp_rdata | output | 16 | Read data back to the fabric, zero unless granted |
| cfg_err | output | 1 | Configuration write rejected |

## Verification
Every fabric result (`periph_sel`, `periph_off`, `periph_we` and `resp_err`) goes through a single register. It is therefore due one clock edge after the edge that samples the request. The bench drives each request on a falling edge, waits for the next rising edge, samples just after it, and drops `req_valid` before the following edge. `cfg_err` and any configuration change follow the same one-edge rule, so a request sent after the write's edge already sees the new setting. `resp_rdata` is combinational from the registered grant, so it is checked in the same sample.

// File: rtl/fag_pkg.sv
package fag_pkg;
  localparam int ADDR_W = 16;
  localparam int WIN_W  = 14;
  localparam int PAGE_W = 12;
  localparam int DATA_W = 16;

  typedef struct packed {
    logic              lock;
    logic              alias_en;
    logic [1:0]        size_sel;
    logic [WIN_W-1:0]  base;
    logic [WIN_W-1:0]  limit;
  } fag_cfg_t;

  // Mask of decoded offset bits for a size setting.
  function automatic logic [WIN_W-1:0] size_mask(input logic [1:0] sel);
    int bits;
    bits = PAGE_W + ((sel > 2'd2) ? 2 : int'(sel));
    if (bits > WIN_W) bits = WIN_W;
    return WIN_W'((32'd1 << bits) - 32'd1);
  endfunction

  function automatic logic in_range(input logic [WIN_W-1:0] off,
                                    input logic [WIN_W-1:0] lo,
                                    input logic [WIN_W-1:0] hi);
    return (off >= lo) && (off <= hi);
  endfunction
endpackage

// File: rtl/fag_cfg_regs.sv
module fag_cfg_regs
  import fag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic              cfg_priv,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output fag_cfg_t          cfg_q,
  output logic              cfg_err
);
  logic wr_ok;
  logic wr_bad;

  assign wr_ok  = cfg_valid && cfg_priv && !cfg_q.lock && (cfg_addr != 2'd3);
  assign wr_bad = cfg_valid && !wr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.lock     <= 1'b0;
      cfg_q.alias_en <= 1'b0;
      cfg_q.size_sel <= 2'd0;
      cfg_q.base     <= '0;
      cfg_q.limit    <= '1;
      cfg_err        <= 1'b0;
    end else begin
      cfg_err <= wr_bad;
      if (wr_ok) begin
        unique case (cfg_addr)
          2'd0: begin
            cfg_q.alias_en <= cfg_wdata[0];
            cfg_q.size_sel <= cfg_wdata[2:1];
            cfg_q.lock     <= cfg_wdata[3];
          end
          2'd1: cfg_q.base  <= cfg_wdata[WIN_W-1:0];
          2'd2: cfg_q.limit <= cfg_wdata[WIN_W-1:0];
          default: ;
        endcase
      end
    end
  end

  a_r8_untrusted_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_priv) |=> ($stable(cfg_q) && cfg_err));
  a_r9_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.lock |=> ($stable(cfg_q) && cfg_q.lock));
endmodule

// File: rtl/fag_decode.sv
module fag_decode
  import fag_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              priv,
  input  fag_cfg_t          cfg,
  output logic              win_hit,
  output logic              prot_hit,
  output logic              grant,
  output logic              deny,
  output logic [WIN_W-1:0]  off
);
  logic [WIN_W-1:0] mask;
  logic             mirror;
  logic             reach;

  always_comb begin
    mask     = size_mask(cfg.size_sel);
    win_hit  = (addr[ADDR_W-1:WIN_W] == '0);
    mirror   = ((addr[WIN_W-1:0] & ~mask) != '0);
    off      = addr[WIN_W-1:0] & mask;
    reach    = win_hit && (!mirror || cfg.alias_en);
    prot_hit = in_range(off, cfg.base, cfg.limit);
    grant    = reach && (priv || !prot_hit);
    deny     = win_hit && !grant;
  end
endmodule

// File: rtl/fab_alias_guard.sv
module fab_alias_guard
  import fag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [15:0]       req_addr,
  input  logic              req_write,
  input  logic              req_priv,
  input  logic [15:0]       periph_rdata,
  input  logic              cfg_valid,
  input  logic              cfg_priv,
  input  logic [1:0]        cfg_addr,
  input  logic [15:0]       cfg_wdata,
  output logic              periph_sel,
  output logic [13:0]       periph_off,
  output logic              periph_we,
  output logic              resp_err,
  output logic [15:0]       resp_rdata,
  output logic              cfg_err
);
  fag_cfg_t         cfg;
  logic             dec_win;
  logic             dec_prot;
  logic             dec_grant;
  logic             dec_deny;
  logic [WIN_W-1:0] dec_off;

  fag_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfg_valid(cfg_valid), .cfg_priv(cfg_priv),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_q(cfg), .cfg_err(cfg_err)
  );

  fag_decode u_dec (
    .addr(req_addr), .priv(req_priv), .cfg(cfg),
    .win_hit(dec_win), .prot_hit(dec_prot),
    .grant(dec_grant), .deny(dec_deny), .off(dec_off)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      periph_sel <= 1'b0;
      periph_off <= '0;
      periph_we  <= 1'b0;
      resp_err   <= 1'b0;
    end else begin
      periph_sel <= req_valid && dec_grant;
      periph_we  <= req_valid && dec_grant && req_write;
      resp_err   <= req_valid && dec_deny;
      if (req_valid && dec_grant) periph_off <= dec_off;
    end
  end

  assign resp_rdata = periph_sel ? periph_rdata : '0;

  a_r1_sel_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_sel || resp_err) |-> ($past(req_addr[ADDR_W-1:WIN_W]) == '0));
  a_r5_unpriv_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    periph_sel |-> ($past(req_priv) || !$past(dec_prot)));
  a_r6_sel_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(periph_sel && resp_err));
  a_r6_zero_when_refused: assert property (@(posedge clk) disable iff (!rst_n)
    !periph_sel |-> (resp_rdata == '0 && !periph_we));
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid) |-> (!periph_sel && !resp_err));
  a_r3_mirror_off_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !cfg.alias_en && dec_win &&
     ((req_addr[WIN_W-1:0] & ~size_mask(cfg.size_sel)) != '0)) |=> resp_err);
endmodule

// File: tb/fab_alias_guard_tb_top.sv
module fab_alias_guard_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_priv = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] periph_rdata = 16'hBEEF;
  logic cfg_valid = 1'b0, cfg_priv = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic periph_sel, periph_we, resp_err, cfg_err;
  logic [13:0] periph_off;
  logic [15:0] resp_rdata;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fab_alias_guard dut_i (.*);

  // Vector: addr[33:18] write[17] priv[16] exp_sel[15] exp_err[14] exp_off[13:0]
  // Config: alias on, 4 KiB, protected 0x000..0x0FF.
  localparam logic [33:0] VEC [10] = '{
    {16'h0010, 1'b0, 1'b0, 1'b0, 1'b1, 14'h000},
    {16'h1010, 1'b0, 1'b0, 1'b0, 1'b1, 14'h000},
    {16'h3010, 1'b1, 1'b0, 1'b0, 1'b1, 14'h000},
    {16'h2010, 1'b0, 1'b1, 1'b1, 1'b0, 14'h010},
    {16'h0100, 1'b0, 1'b0, 1'b1, 1'b0, 14'h100},
    {16'h3100, 1'b1, 1'b0, 1'b1, 1'b0, 14'h100},
    {16'h4000, 1'b0, 1'b1, 1'b0, 1'b0, 14'h000},
    {16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b0, 14'h000},
    {16'h30FF, 1'b0, 1'b0, 1'b0, 1'b1, 14'h000},
    {16'h1FFF, 1'b0, 1'b0, 1'b1, 1'b0, 14'hFFF}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [1:0] a, input logic [15:0] d, input logic p);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_priv = p;
    @(posedge clk); #1;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  // Send one request, sample one edge later.
  task automatic req(input logic [15:0] a, input logic w, input logic p,
                     input logic es, input logic ee, input logic [13:0] eo,
                     input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_priv = p;
    @(posedge clk); #1;
    chk(periph_sel == es, {tag, " sel"}, int'(periph_sel), int'(es));
    chk(resp_err == ee, {tag, " err"}, int'(resp_err), int'(ee));
    if (es) chk(periph_off == eo, {tag, " off"}, int'(periph_off), int'(eo));
    chk(periph_we == (es && w), {tag, " we"}, int'(periph_we), int'(es && w));
    chk(resp_rdata == (es ? 16'hBEEF : 16'h0), {tag, " rdata"},
        int'(resp_rdata), es ? 32'hBEEF : 0);
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk); #1;
    chk(!resp_err && !periph_sel, {tag, " R6 R7 one-cycle"},
        int'({periph_sel, resp_err}), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    // R10 reset state and R7 idle
    chk(!periph_sel && !resp_err && !cfg_err && resp_rdata == 0, "R10 R7 idle after reset",
        int'({periph_sel, resp_err, cfg_err}), 0);
    // R10: whole range protected, alias off
    req(16'h0FFF, 1'b0, 1'b0, 1'b0, 1'b1, 14'h0, "R10 unpriv protected");
    req(16'h0FFF, 1'b0, 1'b1, 1'b1, 1'b0, 14'hFFF, "R10 priv primary");
    // R3 mirror blocked for priv too
    req(16'h1000, 1'b0, 1'b1, 1'b0, 1'b1, 14'h0, "R3 mirror priv");
    req(16'h3ABC, 1'b1, 1'b1, 1'b0, 1'b1, 14'h0, "R3 mirror write");
    // R8 unprivileged write rejected
    cfg_wr(2'd0, 16'h0001, 1'b0);
    chk(cfg_err, "R8 cfg_err unpriv", int'(cfg_err), 1);
    req(16'h1000, 1'b0, 1'b1, 1'b0, 1'b1, 14'h0, "R8 alias still off");
    cfg_wr(2'd3, 16'h0001, 1'b1);
    chk(cfg_err, "R8 cfg_err addr3", int'(cfg_err), 1);
    // Configure for table
    cfg_wr(2'd0, 16'h0001, 1'b1);
    chk(!cfg_err, "R8 priv write ok", int'(cfg_err), 0);
    cfg_wr(2'd1, 16'h0000, 1'b1);
    cfg_wr(2'd2, 16'h00FF, 1'b1);
    // R1 R2 R4 R5 R6 vector walk
    for (int i = 0; i < 10; i++) begin
      req(VEC[i][33:18], VEC[i][17], VEC[i][16], VEC[i][15], VEC[i][14],
          VEC[i][13:0], $sformatf("R1 R2 R4 R5 R6 vec%0d", i));
    end
    // R2 8 KiB folding
    cfg_wr(2'd0, 16'h0003, 1'b1);
    req(16'h3234, 1'b0, 1'b0, 1'b1, 1'b0, 14'h1234, "R2 8K fold");
    req(16'h2080, 1'b0, 1'b0, 1'b0, 1'b1, 14'h0, "R5 8K mirror protected");
    // R2 16 KiB: no mirror, full offset
    cfg_wr(2'd0, 16'h0004, 1'b1);
    req(16'h3FFF, 1'b0, 1'b0, 1'b1, 1'b0, 14'h3FFF, "R2 16K full");
    // R3 8 KiB alias off
    cfg_wr(2'd0, 16'h0002, 1'b1);
    req(16'h1F00, 1'b0, 1'b0, 1'b1, 1'b0, 14'h1F00, "R3 8K primary");
    req(16'h2F00, 1'b0, 1'b1, 1'b0, 1'b1, 14'h0, "R3 8K mirror");
    // R9 lock (alias on, 4K, lock)
    cfg_wr(2'd0, 16'h0009, 1'b1);
    chk(!cfg_err, "R9 lock write ok", int'(cfg_err), 0);
    cfg_wr(2'd2, 16'h0000, 1'b1);
    chk(cfg_err, "R9 locked limit write", int'(cfg_err), 1);
    req(16'h2050, 1'b0, 1'b0, 1'b0, 1'b1, 14'h0, "R9 limit unchanged");
    cfg_wr(2'd0, 16'h0000, 1'b1);
    chk(cfg_err, "R9 locked ctrl write", int'(cfg_err), 1);
    req(16'h1200, 1'b0, 1'b0, 1'b1, 1'b0, 14'h200, "R9 alias still on");
    // R10 reset clears lock
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    cfg_wr(2'd0, 16'h0001, 1'b1);
    chk(!cfg_err, "R10 lock cleared", int'(cfg_err), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule